// File: doc/BRIEF.md
# H-Bridge Impulse Doublet Sequencer

This block is the digital control for a four-arm bridge that drives a transmit antenna with impulse doublets. A fire request starts a two-phase pulse. In the drive phase the two antenna terminals are pulled to opposite supply rails. In the rest phase both terminals are pulled to one shared rail. The block uses a single supply, so the shared rail is always either VDD or VSS. A two-bit mode input chooses how that rail is picked. Two of the modes try to use VDD and VSS equally often over time.

Each arm has two delays, counted in fine clock ticks. One sets how long the arm waits before it turns on, and the other sets how long it stays on after its command drops. These delays line up the switching edges of the different transistors. A break-before-make interlock stops the pull-up and pull-down arms of the same terminal from ever conducting together, even when the programmed delays would make them overlap. Each arm's output is a vector of gate enables, one per section, and a section mask sets the drive strength. A fire request that arrives while a pulse is still running is dropped and counted. A polarity input, sampled when a request is accepted, picks which terminal goes high in the drive phase.

Top module: `doublet_bridge_seq`

## Requirements
- R1: While reset is asserted, and immediately after it is released, every gate-enable output is zero, `busy_o` is 0 and `drop_cnt_o` is 0.
- R2: A fire request in a clock cycle where `busy_o` is 0 is accepted. From the next edge, `busy_o` is 1 and the drive phase lasts `drive_len_i`+1 cycles, with that length sampled at acceptance. In the drive phase, polarity 0 commands up-A and down-B, and polarity 1 commands down-A and up-B. The rest phase follows and lasts `rest_len_i`+1 cycles, with that length sampled when the drive phase ends.
- R3: In the rest phase, a VDD rest commands both up arms and a VSS rest commands both down arms. After the rest phase, all commands drop. `busy_o` returns to 0 one edge after every arm is fully off.
- R4: Mode 00 always rests on VSS. Mode 01 always rests on VDD. The mode is sampled at acceptance.
- R5: Mode 10 rests on the rail given by an alternation flag: 0 means VSS, 1 means VDD. The flag is 0 after reset and toggles on every accepted pulse, whatever the mode.
- R6: A balance value counts VDD rests minus VSS rests since reset, over every mode, and saturates at +31 and -31. Mode 11 picks VDD when the balance is negative and VSS otherwise, so a tie goes to VSS.
- R7: When an arm's command rises at edge E while the arm is off, its output turns on after edge E+make+2. Here make is the arm's 4-bit make delay, loaded at E+1. The interlock of R9 can hold the turn-on back further.
- R8: When an arm's command falls at edge F while the arm is on, its output stays on and turns off after edge F+brk+2. Here brk is the arm's 4-bit break delay, loaded at F+1.
- R9: The up and down arms of the same terminal are never on in the same cycle. An arm whose make delay has run out waits until the other arm on its terminal is off.
- R10: Each arm output equals `sect_en_i` while the arm is on and is zero otherwise.
- R11: Each fire request in a cycle where `busy_o` is 1 is dropped. It has no effect on the pulse in progress, and it raises `drop_cnt_o` by one, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire_i | input | 1 | Pulse request |
| pol_i | input | 1 | Drive-phase polarity, sampled at acceptance |
| mode_i | input | 2 | Rest rail mode (00 VSS, 01 VDD, 10 alternate, 11 balance) |
| drive_len_i | input | 4 | Drive phase length minus one |
| rest_len_i | input | 4 | Rest phase length minus one |
| make_dly_i | input | 16 | Make delays, 4 bits per arm; arm k at bits 4k+3:4k (0 up-A, 1 down-A, 2 up-B, 3 down-B) |
| break_dly_i | input | 16 | Break delays, same layout as make_dly_i |
| sect_en_i | input | 8 | Section enable mask |
| up_a_o | output | 8 | Gate enables, pull-up arm of terminal A |
| dn_a_o | output | 8 | Gate enables, pull-down arm of terminal A |
| up_b_o | output | 8 | Gate enables, pull-up arm of terminal B |
| dn_b_o | output | 8 | Gate enables, pull-down arm of terminal B |
| busy_o | output | 1 | Pulse in progress |
| drop_cnt_o | output | 8 | Count of dropped requests, saturating |

## Verification
The hardest case to reach from the ports is the interlock holding an arm back. It only happens when one arm's break delay is still running after its partner's make delay has expired at the drive-to-rest handover. The stimulus reaches it with a directed pulse: a long break delay on up-A, zero make delay on down-A, polarity 0 and a VSS rest. Balance mode only shows its tie-breaking and saturation after long one-sided runs, so fixed-rail pulses first push the balance to a known sign before balance-mode pulses run. A held fire request then drives the drop counter into saturation. A long random phase mixes every mode, length and delay while a behavioural model is compared on every clock.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int NUM_ARMS = 4;

    // arm order: 0 up-A, 1 down-A, 2 up-B, 3 down-B
    localparam int ARM_UP_A = 0;
    localparam int ARM_DN_A = 1;
    localparam int ARM_UP_B = 2;
    localparam int ARM_DN_B = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_REST  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,
        ARM_MAKE  = 2'd1,
        ARM_ON    = 2'd2,
        ARM_BREAK = 2'd3
    } arm_state_e;

    typedef enum logic [1:0] {
        REST_LOW  = 2'b00,
        REST_HIGH = 2'b01,
        REST_ALT  = 2'b10,
        REST_BAL  = 2'b11
    } rest_mode_e;
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int LEN_W  = 4,
    parameter int DROP_W = 8,
    parameter int BAL_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire_i,
    input  logic                pol_i,
    input  logic [1:0]          mode_i,
    input  logic [LEN_W-1:0]    drive_len_i,
    input  logic [LEN_W-1:0]    rest_len_i,
    input  logic                all_off_i,
    output logic [NUM_ARMS-1:0] arm_tgt_o,
    output phase_e              phase_o,
    output logic                busy_o,
    output logic [DROP_W-1:0]   drop_cnt_o
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = 1;
    localparam logic [DROP_W-1:0] DROP_ONE = 1;
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};
    localparam logic [BAL_W-1:0]  BAL_ONE  = 1;
    localparam logic [BAL_W-1:0]  BAL_HI   = {1'b0, {(BAL_W-1){1'b1}}};
    localparam logic [BAL_W-1:0]  BAL_LO   = {1'b1, {(BAL_W-2){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e              phase;
        logic [LEN_W-1:0]    cnt;
        logic                pol;
        logic                rail;   // 1 = VDD rest, 0 = VSS rest
        logic                alt;
        logic [BAL_W-1:0]    bal;    // two's complement VDD minus VSS
        logic [DROP_W-1:0]   drop;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  pick_d;

    always_comb begin
        unique case (rest_mode_e'(mode_i))
            REST_LOW:  pick_d = 1'b0;
            REST_HIGH: pick_d = 1'b1;
            REST_ALT:  pick_d = cur_q.alt;
            default:   pick_d = cur_q.bal[BAL_W-1];
        endcase
    end

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (fire_i) begin
                    nxt_d.phase = PH_DRIVE;
                    nxt_d.cnt   = drive_len_i;
                    nxt_d.pol   = pol_i;
                    nxt_d.rail  = pick_d;
                    nxt_d.alt   = ~cur_q.alt;
                    if (pick_d) begin
                        if (cur_q.bal != BAL_HI) nxt_d.bal = cur_q.bal + BAL_ONE;
                    end else begin
                        if (cur_q.bal != BAL_LO) nxt_d.bal = cur_q.bal - BAL_ONE;
                    end
                end
            end
            PH_DRIVE: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.phase = PH_REST;
                    nxt_d.cnt   = rest_len_i;
                end else begin
                    nxt_d.cnt = cur_q.cnt - LEN_ONE;
                end
            end
            PH_REST: begin
                if (cur_q.cnt == '0) nxt_d.phase = PH_DRAIN;
                else                 nxt_d.cnt   = cur_q.cnt - LEN_ONE;
            end
            default: begin
                if (all_off_i) nxt_d.phase = PH_IDLE;
            end
        endcase
        if (fire_i && (cur_q.phase != PH_IDLE) && (cur_q.drop != DROP_MAX))
            nxt_d.drop = cur_q.drop + DROP_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, cnt: '0, pol: 1'b0, rail: 1'b0,
                       alt: 1'b0, bal: '0, drop: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        arm_tgt_o = '0;
        unique case (cur_q.phase)
            PH_DRIVE: begin
                arm_tgt_o[ARM_UP_A] = ~cur_q.pol;
                arm_tgt_o[ARM_DN_B] = ~cur_q.pol;
                arm_tgt_o[ARM_DN_A] =  cur_q.pol;
                arm_tgt_o[ARM_UP_B] =  cur_q.pol;
            end
            PH_REST: begin
                arm_tgt_o[ARM_UP_A] =  cur_q.rail;
                arm_tgt_o[ARM_UP_B] =  cur_q.rail;
                arm_tgt_o[ARM_DN_A] = ~cur_q.rail;
                arm_tgt_o[ARM_DN_B] = ~cur_q.rail;
            end
            default: arm_tgt_o = '0;
        endcase
    end

    assign phase_o    = cur_q.phase;
    assign busy_o     = (cur_q.phase != PH_IDLE);
    assign drop_cnt_o = cur_q.drop;
endmodule

// File: rtl/dbs_arm.sv
module dbs_arm
    import dbs_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_i,
    input  logic             peer_on_i,
    input  logic [DLY_W-1:0] make_dly_i,
    input  logic [DLY_W-1:0] break_dly_i,
    output logic             on_o,
    output logic             idle_o
);
    localparam logic [DLY_W-1:0] DLY_ONE = 1;

    typedef struct packed {
        arm_state_e       st;
        logic [DLY_W-1:0] cnt;
    } arm_t;

    arm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ARM_OFF: begin
                if (tgt_i) begin
                    nxt_d.st  = ARM_MAKE;
                    nxt_d.cnt = make_dly_i;
                end
            end
            ARM_MAKE: begin
                if (!tgt_i) begin
                    nxt_d.st = ARM_OFF;
                end else if (cur_q.cnt != '0) begin
                    nxt_d.cnt = cur_q.cnt - DLY_ONE;
                end else if (!peer_on_i) begin
                    nxt_d.st = ARM_ON;
                end
            end
            ARM_ON: begin
                if (!tgt_i) begin
                    nxt_d.st  = ARM_BREAK;
                    nxt_d.cnt = break_dly_i;
                end
            end
            default: begin
                if (tgt_i)                 nxt_d.st  = ARM_ON;
                else if (cur_q.cnt == '0)  nxt_d.st  = ARM_OFF;
                else                       nxt_d.cnt = cur_q.cnt - DLY_ONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ARM_OFF, cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign on_o   = (cur_q.st == ARM_ON) || (cur_q.st == ARM_BREAK);
    assign idle_o = (cur_q.st == ARM_OFF);
endmodule

// File: rtl/doublet_bridge_seq.sv
module doublet_bridge_seq
    import dbs_pkg::*;
#(
    parameter int NSECT  = 8,
    parameter int DLY_W  = 4,
    parameter int LEN_W  = 4,
    parameter int DROP_W = 8,
    parameter int BAL_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fire_i,
    input  logic                      pol_i,
    input  logic [1:0]                mode_i,
    input  logic [LEN_W-1:0]          drive_len_i,
    input  logic [LEN_W-1:0]          rest_len_i,
    input  logic [NUM_ARMS*DLY_W-1:0] make_dly_i,
    input  logic [NUM_ARMS*DLY_W-1:0] break_dly_i,
    input  logic [NSECT-1:0]          sect_en_i,
    output logic [NSECT-1:0]          up_a_o,
    output logic [NSECT-1:0]          dn_a_o,
    output logic [NSECT-1:0]          up_b_o,
    output logic [NSECT-1:0]          dn_b_o,
    output logic                      busy_o,
    output logic [DROP_W-1:0]         drop_cnt_o
);
    logic [NUM_ARMS-1:0] arm_tgt;
    logic [NUM_ARMS-1:0] arm_on;
    logic [NUM_ARMS-1:0] arm_idle;
    phase_e              phase;
    logic [NSECT-1:0]    gate [NUM_ARMS];

    dbs_ctrl #(.LEN_W(LEN_W), .DROP_W(DROP_W), .BAL_W(BAL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire_i),
        .pol_i       (pol_i),
        .mode_i      (mode_i),
        .drive_len_i (drive_len_i),
        .rest_len_i  (rest_len_i),
        .all_off_i   (&arm_idle),
        .arm_tgt_o   (arm_tgt),
        .phase_o     (phase),
        .busy_o      (busy_o),
        .drop_cnt_o  (drop_cnt_o)
    );

    for (genvar k = 0; k < NUM_ARMS; k++) begin : g_arm
        // the partner arm shares the terminal: index with bit 0 flipped
        dbs_arm #(.DLY_W(DLY_W)) u_arm (
            .clk         (clk),
            .rst_n       (rst_n),
            .tgt_i       (arm_tgt[k]),
            .peer_on_i   (arm_on[k ^ 1]),
            .make_dly_i  (make_dly_i[k*DLY_W +: DLY_W]),
            .break_dly_i (break_dly_i[k*DLY_W +: DLY_W]),
            .on_o        (arm_on[k]),
            .idle_o      (arm_idle[k])
        );
        assign gate[k] = arm_on[k] ? sect_en_i : '0;
    end

    assign up_a_o = gate[ARM_UP_A];
    assign dn_a_o = gate[ARM_DN_A];
    assign up_b_o = gate[ARM_UP_B];
    assign dn_b_o = gate[ARM_DN_B];
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
    import dbs_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fire_i,
    input logic                busy_o,
    input logic [DROP_W-1:0]   drop_cnt_o,
    input logic [NUM_ARMS-1:0] arm_tgt,
    input logic [NUM_ARMS-1:0] arm_on,
    input phase_e              phase
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};
    localparam logic [DROP_W-1:0] DROP_ONE = 1;

    assert_side_a_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_on[ARM_UP_A] && arm_on[ARM_DN_A]));

    assert_side_b_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_on[ARM_UP_B] && arm_on[ARM_DN_B]));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !busy_o) |=> busy_o);

    assert_drop_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && busy_o && drop_cnt_o != DROP_MAX) |=> drop_cnt_o == $past(drop_cnt_o) + DROP_ONE);

    assert_rest_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REST) |-> (arm_tgt[ARM_UP_A] == arm_tgt[ARM_UP_B]) &&
                               (arm_tgt[ARM_DN_A] == arm_tgt[ARM_DN_B]) &&
                               (arm_tgt[ARM_UP_A] != arm_tgt[ARM_DN_A]));

    for (genvar k = 0; k < NUM_ARMS; k++) begin : g_arm_chk
        assert_make_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(arm_tgt[k]) && !arm_on[k]) |=> !arm_on[k]);

        assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(arm_tgt[k]) && arm_on[k]) |=> arm_on[k]);
    end
endmodule

bind doublet_bridge_seq dbs_checker #(.DROP_W(DROP_W)) u_dbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire_i),
    .busy_o     (busy_o),
    .drop_cnt_o (drop_cnt_o),
    .arm_tgt    (arm_tgt),
    .arm_on     (arm_on),
    .phase      (phase)
);

// File: tb/doublet_bridge_seq_test.sv
module doublet_bridge_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fire_i = 1'b0;
    logic        pol_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [3:0]  drive_len_i = 4'd0;
    logic [3:0]  rest_len_i = 4'd0;
    logic [15:0] make_dly_i = '0;
    logic [15:0] break_dly_i = '0;
    logic [7:0]  sect_en_i = 8'hFF;
    logic [7:0]  up_a_o, dn_a_o, up_b_o, dn_b_o;
    logic        busy_o;
    logic [7:0]  drop_cnt_o;

    doublet_bridge_seq uut (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .pol_i(pol_i), .mode_i(mode_i),
        .drive_len_i(drive_len_i), .rest_len_i(rest_len_i),
        .make_dly_i(make_dly_i), .break_dly_i(break_dly_i), .sect_en_i(sect_en_i),
        .up_a_o(up_a_o), .dn_a_o(dn_a_o), .up_b_o(up_b_o), .dn_b_o(dn_b_o),
        .busy_o(busy_o), .drop_cnt_o(drop_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase 0 idle, 1 drive, 2 rest, 3 drain; arm 0 off, 1 make, 2 on, 3 break
    int m_ph, m_cnt, m_pol, m_rail, m_alt, m_bal, m_drop, m_mode;
    int a_st[4];
    int a_cnt[4];

    function automatic bit m_tgt(int i);
        if (m_ph == 1) return m_pol ? (i == 1 || i == 2) : (i == 0 || i == 3);
        if (m_ph == 2) return m_rail ? (i == 0 || i == 2) : (i == 1 || i == 3);
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_pol = 0; m_rail = 0; m_alt = 0; m_bal = 0; m_drop = 0; m_mode = 0;
            for (int i = 0; i < 4; i++) begin a_st[i] = 0; a_cnt[i] = 0; end
        end else begin
            int  ns[4];
            int  nc[4];
            bit  t[4];
            bit  on[4];
            bit  quiet;
            int  pick;
            quiet = 1'b1;
            for (int i = 0; i < 4; i++) begin
                t[i]  = m_tgt(i);
                on[i] = (a_st[i] >= 2);
                if (a_st[i] != 0) quiet = 1'b0;
            end
            for (int i = 0; i < 4; i++) begin
                ns[i] = a_st[i]; nc[i] = a_cnt[i];
                case (a_st[i])
                    0: if (t[i]) begin ns[i] = 1; nc[i] = int'(make_dly_i[i*4 +: 4]); end
                    1: if (!t[i]) ns[i] = 0;
                       else if (a_cnt[i] > 0) nc[i] = a_cnt[i] - 1;
                       else if (!on[i ^ 1]) ns[i] = 2;
                    2: if (!t[i]) begin ns[i] = 3; nc[i] = int'(break_dly_i[i*4 +: 4]); end
                    default: if (t[i]) ns[i] = 2;
                             else if (a_cnt[i] == 0) ns[i] = 0;
                             else nc[i] = a_cnt[i] - 1;
                endcase
            end
            if (fire_i && m_ph != 0 && m_drop < 255) m_drop++;
            case (m_ph)
                0: if (fire_i) begin
                       case (mode_i)
                           2'b00: pick = 0;
                           2'b01: pick = 1;
                           2'b10: pick = m_alt;
                           default: pick = (m_bal < 0) ? 1 : 0;
                       endcase
                       m_mode = int'(mode_i);
                       m_rail = pick; m_pol = int'(pol_i); m_alt = 1 - m_alt;
                       if (pick == 1 && m_bal < 31) m_bal++;
                       if (pick == 0 && m_bal > -31) m_bal--;
                       m_ph = 1; m_cnt = int'(drive_len_i);
                   end
                1: if (m_cnt == 0) begin m_ph = 2; m_cnt = int'(rest_len_i); end else m_cnt--;
                2: if (m_cnt == 0) m_ph = 3; else m_cnt--;
                default: if (quiet) m_ph = 0;
            endcase
            for (int i = 0; i < 4; i++) begin a_st[i] = ns[i]; a_cnt[i] = nc[i]; end
        end
    end

    function automatic int exp_gate(int i);
        return (a_st[i] >= 2) ? int'(sect_en_i) : 0;
    endfunction

    // ---------------- compare on every clock, away from the edge ----------------
    always @(negedge clk) begin
        cycles++;
        check("R10 R7 R8 R2", "up_a_o", int'(up_a_o), exp_gate(0));
        check("R10 R7 R8 R3", "dn_a_o", int'(dn_a_o), exp_gate(1));
        check("R10 R7 R8 R2", "up_b_o", int'(up_b_o), exp_gate(2));
        check("R10 R7 R8 R3", "dn_b_o", int'(dn_b_o), exp_gate(3));
        check("R2 R3", "busy_o", int'(busy_o), (m_ph != 0) ? 1 : 0);
        check("R11", "drop_cnt_o", int'(drop_cnt_o), m_drop);
        check("R9", "terminal A overlap", int'((|up_a_o) && (|dn_a_o)), 0);
        check("R9", "terminal B overlap", int'((|up_b_o) && (|dn_b_o)), 0);
        if (rst_n && (|up_a_o) && (|up_b_o)) begin
            if (m_mode == 2)      check("R5", "rest rail VDD seen", 1, m_rail);
            else if (m_mode == 3) check("R6", "rest rail VDD seen", 1, m_rail);
            else                  check("R4", "rest rail VDD seen", 1, m_rail);
        end
        if (rst_n && (|dn_a_o) && (|dn_b_o)) begin
            if (m_mode == 2)      check("R5", "rest rail VSS seen", 0, m_rail);
            else if (m_mode == 3) check("R6", "rest rail VSS seen", 0, m_rail);
            else                  check("R4", "rest rail VSS seen", 0, m_rail);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic pulse(bit pol, logic [1:0] mode, logic [3:0] dl, logic [3:0] rl);
        pol_i = pol; mode_i = mode; drive_len_i = dl; rest_len_i = rl; fire_i = 1'b1;
        tick();
        fire_i = 1'b0;
        for (int w = 0; w < 200 && busy_o; w++) tick();
        tick();
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "busy in reset", int'(busy_o), 0);
        check("R1", "gates in reset", int'(up_a_o | dn_a_o | up_b_o | dn_b_o), 0);
        rst_n = 1'b1;
        tick();
        check("R1", "drop after reset", int'(drop_cnt_o), 0);
        check("R1", "busy after reset", int'(busy_o), 0);

        // fixed rails, mixed delays and masks
        make_dly_i  = {4'd3, 4'd0, 4'd2, 4'd1};
        break_dly_i = {4'd4, 4'd1, 4'd0, 4'd2};
        sect_en_i   = 8'hA5;
        pulse(1'b0, 2'b00, 4'd3, 4'd6);
        sect_en_i   = 8'h0F;
        pulse(1'b1, 2'b01, 4'd5, 4'd7);
        // alternation
        sect_en_i = 8'hFF;
        for (int p = 0; p < 4; p++) pulse(p[0], 2'b10, 4'd4, 4'd8);
        // bias balance upward, then balance mode
        for (int p = 0; p < 3; p++) pulse(1'b0, 2'b01, 4'd2, 4'd6);
        for (int p = 0; p < 5; p++) pulse(p[0], 2'b11, 4'd2, 4'd6);
        // bias downward to saturation, then balance mode
        for (int p = 0; p < 40; p++) pulse(1'b1, 2'b00, 4'd0, 4'd5);
        for (int p = 0; p < 4; p++) pulse(1'b0, 2'b11, 4'd1, 4'd6);
        // interlock: up-A breaks slowly while down-A has no make delay
        make_dly_i  = 16'h0000;
        break_dly_i = {4'd0, 4'd0, 4'd0, 4'd15};
        pulse(1'b0, 2'b00, 4'd2, 4'd15);
        break_dly_i = {4'd15, 4'd0, 4'd0, 4'd0};
        pulse(1'b1, 2'b01, 4'd2, 4'd15);
        // held request: drops counted and saturating
        make_dly_i  = 16'h1111;
        break_dly_i = 16'h2222;
        fire_i = 1'b1; pol_i = 1'b0; mode_i = 2'b10; drive_len_i = 4'd3; rest_len_i = 4'd3;
        repeat (600) tick();
        fire_i = 1'b0;
        for (int w = 0; w < 200 && busy_o; w++) tick();
        // random mix
        for (int c = 0; c < 8000; c++) begin
            fire_i      = ($urandom % 5) == 0;
            pol_i       = $urandom % 2;
            mode_i      = 2'($urandom % 4);
            drive_len_i = 4'($urandom % 8);
            rest_len_i  = 4'($urandom % 12);
            if (($urandom % 50) == 0) begin
                make_dly_i  = 16'($urandom);
                break_dly_i = 16'($urandom);
            end
            sect_en_i = 8'($urandom) | 8'h01;
            tick();
        end
        fire_i = 1'b0;
        repeat (100) tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule